// File: doc/BRIEF.md
# Mode-Selected 32-bit Integer Arithmetic/Logic Unit

This block is the purely combinational arithmetic and logic stage of a small integer pipeline. It takes two operand words and a four-bit operation code and produces a result word together with a carry flag and a signed-overflow flag. The supported operations are signed and unsigned addition and subtraction, four bitwise operations, and signed and unsigned less-than comparison. Immediates must already be extended before they reach the block. Shifts, multiplication and division are handled by other units.

The datapath is a chain of identical one-bit slices. Each slice holds a full adder, an optional inverter on its second operand and an output selector. A small decoder sets the inversion, the carry into bit 0 and the selector code. Logic next to the top slice forms the overflow and less-than bits, and the less-than bit is routed back into slice 0. Subtraction adds the inverted second operand with a carry-in of one. Each comparison reuses that subtraction.

Top module: `alu32`

## Requirements
- R1: Codes 0000 (signed add) and 0001 (unsigned add) give result = A + B modulo 2^32, with carry equal to bit 32 of the full unsigned sum.
- R2: Codes 0010 (signed subtract) and 0011 (unsigned subtract) give result = A - B modulo 2^32, with carry equal to the carry out of A + ~B + 1. The carry is 1 exactly when A >= B as unsigned numbers.
- R3: Overflow is 1 only in codes 0000 and 0010, and only when the true signed result does not fit in 32 bits. Codes 0001 and 0011 always give overflow 0.
- R4: Codes 0100 (AND), 0101 (OR), 0110 (XOR) and 0111 (NOR) give the bitwise result, with carry and overflow both 0.
- R5: Code 1010 gives result 1 when A < B as signed numbers and 0 otherwise. This holds even when A - B overflows.
- R6: Code 1011 gives result 1 when A < B as unsigned numbers and 0 otherwise.
- R7: Both comparison codes place the comparison in bit 0, drive bits 31..1 to 0, and drive carry and overflow to 0.
- R8: Every other code (1000, 1001, 1100 to 1111) gives result 0, carry 0 and overflow 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| mode | input | 4 | Operation code |
| result | output | 32 | Operation result |
| carry | output | 1 | Adder carry out of bit 31 for add and subtract codes, else 0 |
| ovf | output | 1 | Signed overflow for codes 0000 and 0010, else 0 |

## Verification
The assertions are immediate checks evaluated on the settled combinational outputs. They assume that op_a, op_b and mode are always known values and that they change only as whole words. The bench drives every input as a complete word from a task on the falling clock edge and samples one half period later, so the carry chain has settled before any check is made. The stimulus covers all sixteen codes and includes operand pairs at the signed and unsigned extremes, because those pairs exercise the overflow and comparison corners.

// File: rtl/alu32_pkg.sv
package alu32_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    OP_ADD  = 4'b0000,
    OP_ADDU = 4'b0001,
    OP_SUB  = 4'b0010,
    OP_SUBU = 4'b0011,
    OP_AND  = 4'b0100,
    OP_OR   = 4'b0101,
    OP_XOR  = 4'b0110,
    OP_NOR  = 4'b0111,
    OP_SLT  = 4'b1010,
    OP_SLTU = 4'b1011
  } op_code_e;

  typedef enum logic [2:0] {
    PICK_ZERO = 3'd0,
    PICK_AND  = 3'd1,
    PICK_OR   = 3'd2,
    PICK_XOR  = 3'd3,
    PICK_NOR  = 3'd4,
    PICK_SUM  = 3'd5,
    PICK_LESS = 3'd6
  } slice_pick_e;

  typedef struct packed {
    logic        inv_b;
    logic        cin0;
    slice_pick_e pick;
    logic        carry_en;
    logic        ovf_en;
    logic        cmp_signed;
  } alu_ctl_t;
endpackage

// File: rtl/alu32_decode.sv
module alu32_decode
  import alu32_pkg::*;
#(
  parameter int unsigned MW = MODE_W
) (
  input  logic [MW-1:0] mode,
  output alu_ctl_t      ctl
);
  always_comb begin
    ctl = '{inv_b: 1'b0, cin0: 1'b0, pick: PICK_ZERO,
            carry_en: 1'b0, ovf_en: 1'b0, cmp_signed: 1'b0};
    case (mode)
      OP_ADD:  begin ctl.pick = PICK_SUM; ctl.carry_en = 1'b1; ctl.ovf_en = 1'b1; end
      OP_ADDU: begin ctl.pick = PICK_SUM; ctl.carry_en = 1'b1; end
      OP_SUB:  begin ctl.inv_b = 1'b1; ctl.cin0 = 1'b1; ctl.pick = PICK_SUM;
                     ctl.carry_en = 1'b1; ctl.ovf_en = 1'b1; end
      OP_SUBU: begin ctl.inv_b = 1'b1; ctl.cin0 = 1'b1; ctl.pick = PICK_SUM;
                     ctl.carry_en = 1'b1; end
      OP_AND:  ctl.pick = PICK_AND;
      OP_OR:   ctl.pick = PICK_OR;
      OP_XOR:  ctl.pick = PICK_XOR;
      OP_NOR:  ctl.pick = PICK_NOR;
      OP_SLT:  begin ctl.inv_b = 1'b1; ctl.cin0 = 1'b1; ctl.pick = PICK_LESS;
                     ctl.cmp_signed = 1'b1; end
      OP_SLTU: begin ctl.inv_b = 1'b1; ctl.cin0 = 1'b1; ctl.pick = PICK_LESS; end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu32_slice.sv
module alu32_slice
  import alu32_pkg::*;
(
  input  logic        a,
  input  logic        b,
  input  logic        inv,
  input  logic        ci,
  input  logic        less,
  input  slice_pick_e pick,
  output logic        sum,
  output logic        co,
  output logic        res
);
  logic bx;

  always_comb begin
    bx  = b ^ inv;
    sum = a ^ bx ^ ci;
    co  = (a & bx) | (ci & (a ^ bx));
    case (pick)
      PICK_AND:  res = a & b;
      PICK_OR:   res = a | b;
      PICK_XOR:  res = a ^ b;
      PICK_NOR:  res = ~(a | b);
      PICK_SUM:  res = sum;
      PICK_LESS: res = less;
      default:   res = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu32.sv
module alu32
  import alu32_pkg::*;
#(
  parameter int unsigned W  = DATA_W,
  parameter int unsigned MW = MODE_W
) (
  input  logic [W-1:0]  op_a,
  input  logic [W-1:0]  op_b,
  input  logic [MW-1:0] mode,
  output logic [W-1:0]  result,
  output logic          carry,
  output logic          ovf
);
  localparam int unsigned TOP = W - 1;

  alu_ctl_t ctl;
  logic     chain [W+1];
  logic     sums  [W];
  logic     bits  [W];
  logic     ovf_raw;
  logic     lt_bit;

  alu32_decode #(.MW(MW)) u_dec (.mode(mode), .ctl(ctl));

  assign chain[0] = ctl.cin0;

  for (genvar i = 0; i < W; i++) begin : g_slice
    logic less_in;
    if (i == 0) begin : g_lsb
      assign less_in = lt_bit;
    end else begin : g_rest
      assign less_in = 1'b0;
    end
    alu32_slice u_sl (
      .a(op_a[i]), .b(op_b[i]), .inv(ctl.inv_b), .ci(chain[i]),
      .less(less_in), .pick(ctl.pick),
      .sum(sums[i]), .co(chain[i+1]), .res(bits[i])
    );
    assign result[i] = bits[i];
  end

  always_comb begin
    ovf_raw = chain[W] ^ chain[TOP];
    lt_bit  = ctl.cmp_signed ? (sums[TOP] ^ ovf_raw) : ~chain[W];
    carry   = ctl.carry_en & chain[W];
    ovf     = ctl.ovf_en & ovf_raw;
  end
endmodule

// File: rtl/alu32_chk.sv
module alu32_chk #(
  parameter int unsigned W  = 32,
  parameter int unsigned MW = 4
) (
  input logic [W-1:0]  op_a,
  input logic [W-1:0]  op_b,
  input logic [MW-1:0] mode,
  input logic [W-1:0]  result,
  input logic          carry,
  input logic          ovf
);
  always_comb begin
    if (mode == 4'b0000 || mode == 4'b0001) begin
      assert_add_sum_R1: assert ({carry, result} == ({1'b0, op_a} + {1'b0, op_b}));
    end
    if (mode == 4'b0010 || mode == 4'b0011) begin
      assert_sub_diff_R2: assert (result == op_a - op_b && carry == (op_a >= op_b));
    end
    if (mode == 4'b0001 || mode == 4'b0011) begin
      assert_no_overflow_R3: assert (!ovf);
    end
    if (mode[3:2] == 2'b01) begin
      assert_logic_flags_R4: assert (!carry && !ovf);
    end
    if (mode == 4'b1010) begin
      assert_slt_signed_R5: assert (result[0] == ($signed(op_a) < $signed(op_b)));
    end
    if (mode == 4'b1011) begin
      assert_slt_unsigned_R6: assert (result[0] == (op_a < op_b));
    end
    if (mode == 4'b1010 || mode == 4'b1011) begin
      assert_slt_upper_R7: assert (result[W-1:1] == '0 && !carry && !ovf);
    end
    if (mode == 4'b1000 || mode == 4'b1001 || mode[3:2] == 2'b11) begin
      assert_unused_zero_R8: assert (result == '0 && !carry && !ovf);
    end
  end
endmodule

bind alu32 alu32_chk #(.W(W), .MW(MW)) u_chk (
  .op_a(op_a), .op_b(op_b), .mode(mode),
  .result(result), .carry(carry), .ovf(ovf)
);

// File: tb/alu32_test.sv
`timescale 1ns/1ps
module alu32_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a, b;
  logic [3:0]  m;
  logic [31:0] s;
  logic        c, v;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  alu32 uut (.op_a(a), .op_b(b), .mode(m), .result(s), .carry(c), .ovf(v));

  task automatic expect_of(input logic [31:0] ea, input logic [31:0] eb, input logic [3:0] em,
                           output logic [31:0] es, output logic ec, output logic ev);
    logic [32:0] w;
    es = '0; ec = 1'b0; ev = 1'b0;
    case (em)
      4'b0000, 4'b0001: begin
        w = {1'b0, ea} + {1'b0, eb};
        es = w[31:0]; ec = w[32];
        ev = (em == 4'b0000) && (ea[31] == eb[31]) && (es[31] != ea[31]);
      end
      4'b0010, 4'b0011: begin
        w = {1'b0, ea} + {1'b0, ~eb} + 33'd1;
        es = w[31:0]; ec = w[32];
        ev = (em == 4'b0010) && (ea[31] != eb[31]) && (es[31] != ea[31]);
      end
      4'b0100: es = ea & eb;
      4'b0101: es = ea | eb;
      4'b0110: es = ea ^ eb;
      4'b0111: es = ~(ea | eb);
      4'b1010: es = {31'd0, $signed(ea) < $signed(eb)};
      4'b1011: es = {31'd0, ea < eb};
      default: ;
    endcase
  endtask

  task automatic run_one(input string req, input logic [31:0] ta, input logic [31:0] tb_,
                         input logic [3:0] tm);
    logic [31:0] es;
    logic        ec, ev;
    @(negedge clk);
    a = ta; b = tb_; m = tm;
    expect_of(ta, tb_, tm, es, ec, ev);
    @(posedge clk);
    #1;
    checks++;
    if (s !== es || c !== ec || v !== ev) begin
      fails++;
      $display("FAIL %s mode=%b a=%h b=%h actual s=%h c=%b v=%b expected s=%h c=%b v=%b",
               req, tm, ta, tb_, s, c, v, es, ec, ev);
    end
  endtask

  task automatic test_reset_state;
    run_one("R1 reset", 32'h0, 32'h0, 4'b0000);
  endtask

  task automatic test_add;
    run_one("R1", 32'h0000_0007, 32'h0000_0003, 4'b0000);
    run_one("R1", 32'hFFFF_FFFF, 32'h0000_0001, 4'b0001);
    run_one("R1", 32'h8000_0000, 32'h8000_0000, 4'b0001);
  endtask

  task automatic test_sub;
    run_one("R2", 32'h0000_0010, 32'h0000_0003, 4'b0011);
    run_one("R2", 32'h0000_0003, 32'h0000_0010, 4'b0011);
    run_one("R2", 32'h1234_5678, 32'h1234_5678, 4'b0010);
  endtask

  task automatic test_overflow;
    run_one("R3", 32'h7FFF_FFFF, 32'h0000_0001, 4'b0000);
    run_one("R3", 32'h7FFF_FFFF, 32'h0000_0001, 4'b0001);
    run_one("R3", 32'h8000_0000, 32'h0000_0001, 4'b0010);
    run_one("R3", 32'h8000_0000, 32'h0000_0001, 4'b0011);
    run_one("R3", 32'h8000_0000, 32'hFFFF_FFFF, 4'b0000);
  endtask

  task automatic test_logic;
    for (int k = 4; k < 8; k++) begin
      run_one("R4", 32'hF0F0_A5A5, 32'hFF00_3C3C, k[3:0]);
    end
  endtask

  task automatic test_slt;
    run_one("R5", 32'hFFFF_FFFF, 32'h0000_0001, 4'b1010);
    run_one("R5", 32'h8000_0000, 32'h7FFF_FFFF, 4'b1010);
    run_one("R5", 32'h7FFF_FFFF, 32'h8000_0000, 4'b1010);
    run_one("R5", 32'h0000_0005, 32'h0000_0005, 4'b1010);
    run_one("R6", 32'hFFFF_FFFF, 32'h0000_0001, 4'b1011);
    run_one("R6", 32'h0000_0001, 32'hFFFF_FFFF, 4'b1011);
    run_one("R7", 32'h0000_0000, 32'hFFFF_FFFF, 4'b1011);
  endtask

  task automatic test_unused;
    for (int k = 8; k < 16; k++) begin
      if (k != 10 && k != 11) run_one("R8", 32'hFFFF_FFFF, 32'hFFFF_FFFF, k[3:0]);
    end
  endtask

  task automatic test_sweep;
    logic [31:0] x;
    x = 32'h1357_9BDF;
    for (int n = 0; n < 64; n++) begin
      x = {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
      run_one("R1 R2 R5 R6 sweep", x, {x[15:0], x[31:16]} ^ 32'h8000_0001, n[3:0]);
    end
  endtask

  initial begin
    a = '0; b = '0; m = '0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    test_reset_state();
    test_add();
    test_sub();
    test_overflow();
    test_logic();
    test_slt();
    test_unused();
    test_sweep();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          checks++;
          fails++;
          $display("FAIL watchdog actual=timeout expected=completion");
        end
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule